// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store request into the stream of per-element byte addresses that a multi-lane memory pipeline needs. A request carries a scalar base address, a signed scalar stride, an access mode, an element width code and a vector length. The block then emits one group of up to `LANES` addresses per cycle. Each lane position carries a valid bit, a byte address and the number of the element it holds.

Three access patterns are supported. Unit stride advances by the element size. Constant stride advances by a signed byte distance. Indexed (gather/scatter) access adds a signed per-element offset to the base. In indexed mode the offsets arrive in beats of `LANES` values over a valid/ready handshake. Address generation stalls while no beat is offered. A one-cycle `done` pulse marks the end of each request. Translation, data movement and alignment are handled by other blocks.

Top module: `vaddr_gen`

## Requirements
- R1: With `acc_mode` = 0 (unit stride), element e is at `base_addr + e*B`, where B = 2, 4, 8 bytes for `elem_w` codes 0, 1, 2. Code 3 behaves as code 2. `acc_mode` code 3 behaves as unit stride.
- R2: With `acc_mode` = 1 (strided), element e is at `base_addr + e*stride`, where `stride` is a signed two's-complement byte distance.
- R3: With `acc_mode` = 2 (indexed), element e is at `base_addr + sext(idx)`. For lane l the offset is the signed `IDX_W`-bit slice of `idx_data` at bits `l*IDX_W` upward.
- R4: Each issue cycle serves up to `LANES` consecutive elements. Lane l holds element `g*LANES + l` of group g, and reports that number on `lane_elem`.
- R5: When fewer than `LANES` elements remain, only the low lanes that carry them are valid, and the upper lanes' valid bits are 0.
- R6: `vlen` is clamped to a maximum of `MAX_VL_NARROW` (128) for 16-bit elements, half that (64) for 32-bit elements and a quarter (32) for 64-bit elements.
- R7: A request with `vlen` = 0 produces no valid lane. It raises `done` in the cycle after `start`.
- R8: `done` is a one-cycle pulse in the cycle after the last group is issued. In that cycle `busy` is already 0.
- R9: In indexed mode `idx_ready` is high while busy. While `idx_valid` is low no lane is valid and no progress is made. A beat is consumed in each cycle in which `idx_valid` and `idx_ready` are both high.
- R10: `start` and the request inputs are ignored while `busy` is high. The running request's addresses are unaffected.
- R11: After reset, `busy`, `done`, `idx_ready` and all lane valid bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new request when idle |
| acc_mode | input | 2 | 0 unit stride, 1 strided, 2 indexed, 3 as unit stride |
| elem_w | input | 2 | 0: 16-bit, 1: 32-bit, 2 or 3: 64-bit elements |
| base_addr | input | ADDR_W | Scalar base byte address |
| stride | input | ADDR_W | Signed byte stride for strided mode |
| vlen | input | VL_W | Requested vector length |
| idx_valid | input | 1 | Index beat offered |
| idx_ready | output | 1 | Index beat accepted in indexed mode |
| idx_data | input | LANES*IDX_W | One signed offset per lane |
| busy | output | 1 | A request is in progress |
| lane_valid | output | LANES | Per-lane address valid |
| lane_addr | output | LANES*ADDR_W | Per-lane byte address |
| lane_elem | output | LANES*VL_W | Per-lane element number |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The hardest situation to reach is an indexed request that stalls partway. Here the handshake must freeze the element counter without losing the partially served group position. The stimulus starts an indexed request with a length that is not a multiple of the lane count. It withholds `idx_valid` for a cycle after the first group, then confirms that no lane is valid and that the next beat resumes at element 4. In the same run, `start` is pulsed with a different base while busy, to show that the running request keeps its original base.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT   = 2'd0,
        MODE_STRIDE = 2'd1,
        MODE_INDEX  = 2'd2,
        MODE_RSVD   = 2'd3
    } acc_mode_e;

    // log2 of element bytes minus one: 0 -> 2B, 1 -> 4B, 2 -> 8B
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        return (code > 2'd2) ? 2'd2 : code;
    endfunction

    function automatic int unsigned elem_bytes(input logic [1:0] code);
        return 2 << width_shift(code);
    endfunction

endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl import vag_pkg::*; #(
    parameter int ADDR_W        = 32,
    parameter int LANES         = 4,
    parameter int MAX_VL_NARROW = 128,
    parameter int VL_W          = $clog2(MAX_VL_NARROW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        acc_mode,
    input  logic [1:0]        elem_w,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VL_W-1:0]   vlen,
    input  logic              idx_valid,
    output logic              busy_q,
    output logic              fire,
    output acc_mode_e         mode_q,
    output logic [1:0]        ew_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] step_q,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [VL_W-1:0]   cnt_q,
    output logic [VL_W-1:0]   remain,
    output logic              done_q
);
    localparam logic [VL_W-1:0] LANES_V = VL_W'(LANES);

    logic [VL_W-1:0] vl_q;
    logic [VL_W-1:0] vl_max;
    logic [VL_W-1:0] vl_eff;
    logic            accept;
    logic            last;
    acc_mode_e       mode_in;

    assign mode_in = acc_mode_e'(acc_mode);
    assign vl_max  = VL_W'(MAX_VL_NARROW >> width_shift(elem_w));
    assign vl_eff  = (vlen > vl_max) ? vl_max : vlen;
    assign accept  = start && !busy_q;
    assign remain  = vl_q - cnt_q;
    assign last    = (remain <= LANES_V);
    assign fire    = busy_q && ((mode_q != MODE_INDEX) || idx_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            mode_q <= MODE_UNIT;
            ew_q   <= '0;
            base_q <= '0;
            step_q <= '0;
            ptr_q  <= '0;
            cnt_q  <= '0;
            vl_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                mode_q <= (mode_in == MODE_RSVD) ? MODE_UNIT : mode_in;
                ew_q   <= elem_w;
                base_q <= base_addr;
                ptr_q  <= base_addr;
                step_q <= (mode_in == MODE_STRIDE) ? stride
                                                   : ADDR_W'(elem_bytes(elem_w));
                cnt_q  <= '0;
                vl_q   <= vl_eff;
                busy_q <= (vl_eff != '0);
                done_q <= (vl_eff == '0);
            end else if (fire) begin
                cnt_q <= cnt_q + LANES_V;
                ptr_q <= ptr_q + step_q * ADDR_W'(LANES);
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vag_lane.sv
module vag_lane import vag_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int VL_W   = 8,
    parameter int LANE   = 0
) (
    input  logic              fire,
    input  acc_mode_e         mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] step,
    input  logic [IDX_W-1:0]  idx,
    input  logic [VL_W-1:0]   cnt,
    input  logic [VL_W-1:0]   remain,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic [VL_W-1:0]   elem
);
    localparam logic [VL_W-1:0]   LANE_V = VL_W'(LANE);
    localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(LANE);

    logic [ADDR_W-1:0] idx_ext;

    assign idx_ext = ADDR_W'(signed'(idx));
    assign valid   = fire && (LANE_V < remain);
    assign elem    = cnt + LANE_V;

    always_comb begin
        if (mode == MODE_INDEX) addr = base + idx_ext;
        else                    addr = ptr + step * LANE_A;
    end
endmodule

// File: rtl/vaddr_gen.sv
module vaddr_gen import vag_pkg::*; #(
    parameter int ADDR_W        = 32,
    parameter int IDX_W         = 16,
    parameter int LANES         = 4,
    parameter int MAX_VL_NARROW = 128,
    parameter int VL_W          = $clog2(MAX_VL_NARROW + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [1:0]              acc_mode,
    input  logic [1:0]              elem_w,
    input  logic [ADDR_W-1:0]       base_addr,
    input  logic [ADDR_W-1:0]       stride,
    input  logic [VL_W-1:0]         vlen,
    input  logic                    idx_valid,
    output logic                    idx_ready,
    input  logic [LANES*IDX_W-1:0]  idx_data,
    output logic                    busy,
    output logic [LANES-1:0]        lane_valid,
    output logic [LANES*ADDR_W-1:0] lane_addr,
    output logic [LANES*VL_W-1:0]   lane_elem,
    output logic                    done
);
    logic              busy_q;
    logic              fire;
    acc_mode_e         mode_q;
    logic [1:0]        ew_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] step_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [VL_W-1:0]   cnt_q;
    logic [VL_W-1:0]   remain;
    logic              done_q;

    vag_ctrl #(
        .ADDR_W(ADDR_W), .LANES(LANES),
        .MAX_VL_NARROW(MAX_VL_NARROW), .VL_W(VL_W)
    ) i_ctrl (
        .clk(clk), .rst(rst), .start(start), .acc_mode(acc_mode),
        .elem_w(elem_w), .base_addr(base_addr), .stride(stride),
        .vlen(vlen), .idx_valid(idx_valid), .busy_q(busy_q), .fire(fire),
        .mode_q(mode_q), .ew_q(ew_q), .base_q(base_q), .step_q(step_q),
        .ptr_q(ptr_q), .cnt_q(cnt_q), .remain(remain), .done_q(done_q)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vag_lane #(
            .ADDR_W(ADDR_W), .IDX_W(IDX_W), .VL_W(VL_W), .LANE(l)
        ) i_lane (
            .fire(fire), .mode(mode_q), .base(base_q), .ptr(ptr_q),
            .step(step_q), .idx(idx_data[l*IDX_W +: IDX_W]), .cnt(cnt_q),
            .remain(remain), .valid(lane_valid[l]),
            .addr(lane_addr[l*ADDR_W +: ADDR_W]),
            .elem(lane_elem[l*VL_W +: VL_W])
        );
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign idx_ready = busy_q && (mode_q == MODE_INDEX);
endmodule

// File: rtl/vag_checker.sv
module vag_checker import vag_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4,
    parameter int VL_W   = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic [VL_W-1:0]         vlen,
    input logic                    idx_valid,
    input logic                    idx_ready,
    input logic                    busy,
    input logic [LANES-1:0]        lane_valid,
    input logic [LANES*ADDR_W-1:0] lane_addr,
    input logic                    done,
    input acc_mode_e               mode_q,
    input logic [1:0]              ew_q
);
    AST_IDX_STALL: assert property (@(posedge clk) disable iff (rst)
        idx_ready && !idx_valid |-> lane_valid == '0);                     // R9

    AST_MASK_LOW: assert property (@(posedge clk) disable iff (rst)
        ((lane_valid + 1'b1) & lane_valid) == '0);                         // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                   // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lane_valid == '0) && !idx_ready);                       // R11

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        start && !busy && (vlen == '0) |=> done && (lane_valid == '0));    // R7

    if (LANES > 1) begin : g_spacing
        AST_UNIT_SPACING: assert property (@(posedge clk) disable iff (rst)
            busy && (mode_q == MODE_UNIT) && lane_valid[1]
            |-> (lane_addr[ADDR_W +: ADDR_W] - lane_addr[0 +: ADDR_W])
                == ADDR_W'(elem_bytes(ew_q)));                             // R1
    end
endmodule

bind vaddr_gen vag_checker #(
    .ADDR_W(ADDR_W), .LANES(LANES), .VL_W(VL_W)
) i_vag_checker (
    .clk(clk), .rst(rst), .start(start), .vlen(vlen),
    .idx_valid(idx_valid), .idx_ready(idx_ready), .busy(busy),
    .lane_valid(lane_valid), .lane_addr(lane_addr), .done(done),
    .mode_q(mode_q), .ew_q(ew_q)
);

// File: tb/test_vaddr_gen.sv
module test_vaddr_gen;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 16;
    localparam int LANES  = 4;
    localparam int VL_W   = 8;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic [1:0]              acc_mode = '0;
    logic [1:0]              elem_w = '0;
    logic [ADDR_W-1:0]       base_addr = '0;
    logic [ADDR_W-1:0]       stride = '0;
    logic [VL_W-1:0]         vlen = '0;
    logic                    idx_valid = 1'b0;
    logic                    idx_ready;
    logic [LANES*IDX_W-1:0]  idx_data = '0;
    logic                    busy;
    logic [LANES-1:0]        lane_valid;
    logic [LANES*ADDR_W-1:0] lane_addr;
    logic [LANES*VL_W-1:0]   lane_elem;
    logic                    done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vaddr_gen i_vaddr_gen (
        .clk(clk), .rst(rst), .start(start), .acc_mode(acc_mode),
        .elem_w(elem_w), .base_addr(base_addr), .stride(stride),
        .vlen(vlen), .idx_valid(idx_valid), .idx_ready(idx_ready),
        .idx_data(idx_data), .busy(busy), .lane_valid(lane_valid),
        .lane_addr(lane_addr), .lane_elem(lane_elem), .done(done)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    function automatic logic [IDX_W-1:0] idx_of(input int e);
        return IDX_W'(((e * 37) % 61 - 30) * 8);
    endfunction

    // One complete request; gap inserts an index stall after group 0,
    // poke pulses start with another base while busy.
    task automatic run_vec(input int md, input int ew, input logic [31:0] b,
                           input int st, input int vl, input string rq,
                           input bit gap, input bit poke);
        int sh = (ew > 2) ? 2 : ew;
        int maxv = 128 >> sh;
        int n = (vl > maxv) ? maxv : vl;
        int eb = 2 << sh;
        @(negedge clk);
        start = 1'b1; acc_mode = 2'(md); elem_w = 2'(ew);
        base_addr = b; stride = st; vlen = VL_W'(vl);
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            #1;
            chk(done === 1'b1, "R7 done after zero length", done, 1);
            chk(lane_valid === '0, "R7 no lanes", lane_valid, 0);
            return;
        end
        for (int g = 0; g * LANES < n; g++) begin
            if (md == 2 && gap && g == 1) begin
                idx_valid = 1'b0; #1;
                chk(idx_ready === 1'b1, "R9 ready while busy", idx_ready, 1);
                chk(lane_valid === '0, "R9 stall no lanes", lane_valid, 0);
                @(negedge clk);
            end
            if (poke && g == 1) begin
                start = 1'b1; base_addr = b ^ 32'h00F0_0000; vlen = 8'd3;
            end
            if (md == 2) begin
                idx_valid = 1'b1;
                for (int l = 0; l < LANES; l++)
                    idx_data[l*IDX_W +: IDX_W] = idx_of(g * LANES + l);
            end
            #1;
            for (int l = 0; l < LANES; l++) begin
                int e = g * LANES + l;
                logic [31:0] ea;
                if (md == 1)      ea = b + 32'(e * st);
                else if (md == 2) ea = b + 32'(signed'(idx_of(e)));
                else              ea = b + 32'(e * eb);
                if (e < n) begin
                    chk(lane_valid[l] === 1'b1, {rq, " R4 lane valid"}, lane_valid, l);
                    chk(lane_addr[l*ADDR_W +: ADDR_W] === ea, rq,
                        lane_addr[l*ADDR_W +: ADDR_W], ea);
                    chk(lane_elem[l*VL_W +: VL_W] === VL_W'(e), "R4 element tag",
                        lane_elem[l*VL_W +: VL_W], e);
                end else begin
                    chk(lane_valid[l] === 1'b0, "R5 unused lane off", lane_valid, l);
                end
            end
            chk(done === 1'b0, "R8 no early done", done, 0);
            @(negedge clk);
            start = 1'b0;
        end
        idx_valid = 1'b0;
        #1;
        chk(done === 1'b1, "R8 done pulse", done, 1);
        chk(busy === 1'b0, "R8 idle at done", busy, 0);
        chk(lane_valid === '0, "R8 no lanes at done", lane_valid, 0);
        @(negedge clk); #1;
        chk(done === 1'b0, "R8 done one cycle", done, 0);
    endtask

    task automatic t_reset();
        #1;
        chk(busy === 1'b0 && done === 1'b0, "R11 reset busy/done", {busy, done}, 0);
        chk(lane_valid === '0 && idx_ready === 1'b0, "R11 reset lanes", lane_valid, 0);
    endtask

    task automatic t_unit();
        run_vec(0, 0, 32'h1000, 0, 10, "R1 unit 16b", 0, 0);
        run_vec(0, 1, 32'h2000, 0, 8, "R1 unit 32b", 0, 0);
        run_vec(0, 2, 32'h3000, 0, 5, "R1 unit 64b", 0, 0);
        run_vec(3, 3, 32'h3800, 0, 3, "R1 reserved codes", 0, 0);
    endtask

    task automatic t_stride();
        run_vec(1, 1, 32'h4000, 12, 7, "R2 stride +12", 0, 0);
        run_vec(1, 0, 32'h5000, -6, 9, "R2 stride -6", 0, 0);
    endtask

    task automatic t_index();
        run_vec(2, 1, 32'h8000, 0, 6, "R3 indexed", 0, 0);
        run_vec(2, 0, 32'h9000, 0, 11, "R3 indexed stall R9 R10", 1, 1);
    endtask

    task automatic t_limits();
        run_vec(0, 0, 32'h0, 0, 200, "R6 clamp 16b", 0, 0);
        run_vec(0, 1, 32'h0, 0, 200, "R6 clamp 32b", 0, 0);
        run_vec(1, 2, 32'h100, 8, 40, "R6 clamp 64b", 0, 0);
        run_vec(0, 1, 32'h0, 0, 0, "R7 zero", 0, 0);
        run_vec(0, 1, 32'h40, 0, 4, "R5 exact group", 0, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_unit();
                t_stride();
                t_index();
                t_limits();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule